// File: doc/BRIEF.md
# Sleep Entry and Exit Sequencer

This block sits in front of the core of a synchronous memory and manages a low-power sleep state. An external sleep request pin is asynchronous to the memory clock. The block passes it through a synchronizer and then runs a fixed sequence. When the request appears, the block spends a set number of cycles entering sleep. It stays asleep while the request is held. When the request drops, it spends the same number of cycles recovering before the core may be accessed again.

The core treats `access_ok` as its permission to start or finish an access. That permission is withdrawn as soon as entry begins, and it stays withdrawn until recovery ends. Stored contents are therefore never disturbed while the part sleeps. Any access still in flight when entry begins is discarded, and a one-cycle flag reports it. Two other one-cycle flags report protocol violations: a chip select active when the sleep sequence starts, and any chip select seen during recovery. Chip selects have no effect on the sequence.

Top module: `sleep_seq`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `access_ok` is 1 and `asleep`, `abort_flag`, `sel_err` and `rec_err` are 0.
- R2: The request passes through two clocked stages. If `sleep_req` goes high before rising edge k, `access_ok` is still 1 after edges k and k+1 and falls after edge k+2.
- R3: Entry lasts two cycles. `asleep` rises after the second rising edge following the fall of `access_ok`.
- R4: If `sleep_req` goes low before edge j while the block is asleep, `asleep` falls after edge j+2. `access_ok` rises two edges after that.
- R5: `access_ok` is 1 only in the awake state. It is 0 during entry, during sleep and during recovery, and it is never 1 at the same time as `asleep`.
- R6: `abort_flag` is high for exactly the one cycle that follows the edge where entry begins, and only if `acc_pend` was high at that edge.
- R7: `sel_err` is high for exactly the one cycle that follows the edge where entry begins, and only if `chip_sel` was high at that edge.
- R8: `rec_err` is high for the cycle after any edge at which the block is recovering and `chip_sel` is high. Chip selects never change the state sequence.
- R9: Once entry starts it always reaches sleep, even if the request drops during entry. Once recovery starts it always reaches the awake state, even if the request returns during recovery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req | input | 1 | Sleep request, asynchronous to clk |
| chip_sel | input | 1 | Combined chip select, active high |
| acc_pend | input | 1 | An access is in flight in the core |
| asleep | output | 1 | Sleep state is active |
| access_ok | output | 1 | The core may perform accesses |
| abort_flag | output | 1 | Pulse: a pending access was discarded at entry |
| sel_err | output | 1 | Pulse: chip select was active when entry began |
| rec_err | output | 1 | Pulse: chip select seen during recovery, and ignored |

## Verification
A wrong state or a wrong count shows up at `access_ok` and `asleep` within one cycle. A state that is off by one cycle moves the fall or rise of one of those two outputs by one edge, so every request toggle is compared edge by edge against a reference model in the bench. A flag raised in the wrong state shows up at the very next edge, as a pulse where the model expects none. Random request, select and pending patterns are mixed with directed latency walks. These cover a request that drops during entry and a request that returns during recovery.

// File: rtl/sleep_seq.sv
module sleep_seq #(
  parameter int SEQ_CYCLES  = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_req,
  input  logic chip_sel,
  input  logic acc_pend,
  output logic asleep,
  output logic access_ok,
  output logic abort_flag,
  output logic sel_err,
  output logic rec_err
);
  localparam int CW = $clog2(SEQ_CYCLES + 1);

  typedef enum logic [1:0] {AWAKE, ENTERING, ASLEEP, EXITING} st_t;

  st_t                    st;
  logic [CW-1:0]          cnt;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   req_s, done;

  assign req_s = sync_q[SYNC_STAGES-1];
  assign done  = (cnt == CW'(SEQ_CYCLES - 1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], sleep_req};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= AWAKE;
      cnt        <= '0;
      abort_flag <= 1'b0;
      sel_err    <= 1'b0;
      rec_err    <= 1'b0;
    end else begin
      abort_flag <= 1'b0;
      sel_err    <= 1'b0;
      rec_err    <= (st == EXITING) && chip_sel;
      case (st)
        AWAKE: if (req_s) begin
          st         <= ENTERING;
          cnt        <= '0;
          abort_flag <= acc_pend;
          sel_err    <= chip_sel;
        end
        ENTERING: if (done) st <= ASLEEP; else cnt <= cnt + 1'b1;
        ASLEEP: if (!req_s) begin
          st  <= EXITING;
          cnt <= '0;
        end
        EXITING: if (done) st <= AWAKE; else cnt <= cnt + 1'b1;
        default: st <= AWAKE;
      endcase
    end
  end

  assign asleep    = (st == ASLEEP);
  assign access_ok = (st == AWAKE);

  a_r5_no_access_asleep: assert property (@(posedge clk) disable iff (!rst_n)
    asleep |-> !access_ok);
  a_r3_sleep_from_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(asleep) |-> $past(st) == ENTERING);
  a_r9_wake_from_exit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(access_ok) |-> $past(st) == EXITING);
  a_r6_abort_at_entry: assert property (@(posedge clk) disable iff (!rst_n)
    abort_flag |-> (st == ENTERING && $past(st) == AWAKE));
  a_r7_selerr_at_entry: assert property (@(posedge clk) disable iff (!rst_n)
    sel_err |-> (st == ENTERING && $past(st) == AWAKE));
  a_r8_recerr_in_exit: assert property (@(posedge clk) disable iff (!rst_n)
    rec_err |-> $past(st) == EXITING);
  a_r2_entry_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(access_ok) |-> $past(req_s));
endmodule

// File: tb/sim_sleep_seq.sv
module sim_sleep_seq;
  logic clk = 0, rst_n = 0, sleep_req = 0, chip_sel = 0, acc_pend = 0;
  logic asleep, access_ok, abort_flag, sel_err, rec_err;
  int checks = 0, errors = 0;
  bit cmp_on = 0, done = 0;

  always #10 clk = ~clk;

  sleep_seq u0 (.clk, .rst_n, .sleep_req, .chip_sel, .acc_pend,
                .asleep, .access_ok, .abort_flag, .sel_err, .rec_err);

  // reference model (states: 0 awake, 1 entering, 2 asleep, 3 exiting)
  logic m_s1, m_s2, m_ab, m_se, m_re;
  int   m_st, m_cnt;
  always @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      m_s1 <= 0; m_s2 <= 0; m_st <= 0; m_cnt <= 0; m_ab <= 0; m_se <= 0; m_re <= 0;
    end else begin
      m_s1 <= sleep_req; m_s2 <= m_s1;
      m_ab <= 0; m_se <= 0; m_re <= (m_st == 3) && chip_sel;
      case (m_st)
        0: if (m_s2) begin m_st <= 1; m_cnt <= 0; m_ab <= acc_pend; m_se <= chip_sel; end
        1: if (m_cnt == 1) m_st <= 2; else m_cnt <= m_cnt + 1;
        2: if (!m_s2) begin m_st <= 3; m_cnt <= 0; end
        default: if (m_cnt == 1) m_st <= 0; else m_cnt <= m_cnt + 1;
      endcase
    end

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (cmp_on) begin
    chk("R3 R4 asleep", asleep, m_st == 2);
    chk("R5 access_ok", access_ok, m_st == 0);
    chk("R6 abort_flag", abort_flag, m_ab);
    chk("R7 sel_err", sel_err, m_se);
    chk("R8 rec_err", rec_err, m_re);
  end

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed));
    @(negedge clk);
    chk("R1 reset access_ok", access_ok, 1); chk("R1 reset asleep", asleep, 0);
    chk("R1 reset flags", abort_flag | sel_err | rec_err, 0);
    step(2); rst_n = 1;
    step(1);
    chk("R1 after reset access_ok", access_ok, 1); chk("R1 after reset asleep", asleep, 0);
    cmp_on = 1;
    // R2/R3 directed entry with pending access and select
    sleep_req = 1; acc_pend = 1; chip_sel = 1;
    step(1); chk("R2 edge k", access_ok, 1);
    step(1); chk("R2 edge k+1", access_ok, 1);
    step(1); chk("R2 edge k+2", access_ok, 0);
    chk("R6 pending flagged", abort_flag, 1); chk("R7 select flagged", sel_err, 1);
    acc_pend = 0; chip_sel = 0;
    step(1); chk("R3 still entering", asleep, 0); chk("R6 pulse one cycle", abort_flag, 0);
    step(1); chk("R3 asleep", asleep, 1);
    // R4 exit with select during recovery
    step(3); sleep_req = 0;
    step(1); chk("R4 edge j", asleep, 1);
    step(1); chk("R4 edge j+1", asleep, 1);
    step(1); chk("R4 edge j+2", asleep, 0); chk("R5 recovering", access_ok, 0);
    chip_sel = 1;
    step(1); chk("R8 select ignored", access_ok, 0); chk("R8 flagged", rec_err, 1);
    chip_sel = 0;
    step(1); chk("R4 awake", access_ok, 1);
    // R9 short pulse: entry completes and then exits
    sleep_req = 1; step(1); sleep_req = 0;
    step(4); chk("R9 entry completes", asleep, 1);
    step(5); chk("R9 back awake", access_ok, 1);
    // random phase
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(11) == 0) sleep_req = ~sleep_req;
      chip_sel = ($urandom_range(2) == 0);
      acc_pend = ($urandom_range(2) == 0);
      step(1);
    end
    cmp_on = 0;
    finish_run();
  end
endmodule